// File: doc/BRIEF.md
# Nibble-Loaded Bank Register File

This block holds the bank registers of a cartridge banking personality in which each character-pattern bank number is assembled from two separate four-bit writes. CPU writes in the upper half of the program address space load two 8 KiB program-bank registers, one mirroring bit and eight 1 KiB pattern-bank registers. From these registers the block produces four program page numbers, eight pattern page numbers and a nametable arrangement select. The ROM arrays and the picture processor sit outside this block.

A mode selector elsewhere drives `wr_en` high only while this personality is active. Writes that arrive with `wr_en` low are dropped. All page outputs are combinational from the registers, so a write is visible on the outputs from the clock edge that captures it. The two upper program pages track a program bank count that arrives as a configuration input. The pattern pages carry an outer bank bit above the 8-bit register value.

Top module: `nibble_bank_mapper`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the registers take their reset values: pattern slots 0 to 3 hold 0xFF, slots 4 to 7 hold 4, 5, 6 and 7, program registers 0 and 1 hold 0 and 1, and the mirroring bit is 0.
- R2: A write pulse (`cpu_wr` high) with `wr_en` low changes no register.
- R3: Addresses from 0xB000 to 0xE003 select a pattern slot equal to ({addr[13:12], addr[11] OR addr[1]} + 2) modulo 8. This maps 0xB000, 0xB002, 0xC000, 0xC002, 0xD000, 0xD002, 0xE000 and 0xE002 to slots 0 to 7, and 0xB800 behaves like 0xB002.
- R4: A pattern write with addr[0] = 0 replaces bits 3:0 of the slot with data[3:0] and keeps bits 7:4.
- R5: A pattern write with addr[0] = 1 replaces bits 7:4 of the slot with data[3:0] and keeps bits 3:0.
- R6: Outside the pattern range, a write with addr[15:12] = 0x8 loads the full byte into program register 0, and one with addr[15:12] = 0xA loads it into program register 1. These registers drive program pages 0 and 1.
- R7: A write with addr[15:12] = 0x9 stores data[0] as the mirroring bit, and `mirror_horiz` follows that bit (1 = horizontal, 0 = vertical).
- R8: Program page 2 is (count - 2) mod count and page 3 is (count - 1) mod count, where count is `prg_bank_count`. Count 1 gives 0 for both pages, and count 0 stands for 256 (pages 254 and 255).
- R9: Each pattern page output is {`chr_outer`, slot register}, 9 bits wide.
- R10: Writes below 0x8000, from 0xE004 to 0xEFFF, and at 0xF000 and above change no register.
- R11: A write changes the outputs only after the rising edge on which `cpu_wr` is high. Before that edge the outputs keep their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Personality active; gates all writes |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| prg_bank_count | input | 8 | Number of 8 KiB program banks (0 means 256) |
| chr_outer | input | 1 | Outer pattern bank bit |
| prg_pages | output | 32 | Program pages; page i at bits [8i+7:8i] |
| chr_pages | output | 72 | Pattern pages; slot i at bits [9i+8:9i] |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
The hardest state to reach is a pattern slot that holds a mixed value, with a high nibble from one write and a low nibble from another, reached through an address that decodes to the slot only because of the unusual slot formula, such as 0xB800 landing on slot 1. The stimulus table first writes each nibble of a slot separately, using data whose upper four bits would corrupt the result if they leaked in. It then revisits slots through aliased addresses and through addresses just past the decoded range, reading the result back on the page outputs after each write. Separate directed steps change the bank count to its wrap cases and raise the outer bit over the values already loaded.

// File: rtl/nbr_pkg.sv
// Shared constants and types for the nibble-loaded bank register file.
// Assumes 8-bit pattern registers built from two 4-bit halves.
package nbr_pkg;
    localparam int NIB_W      = 4;
    localparam int CHR_REG_W  = 2 * NIB_W;
    localparam int CHR_SLOTS  = 8;
    localparam int SLOT_W     = $clog2(CHR_SLOTS);
    localparam int PRG_SLOTS  = 4;
    localparam int CHR_PAGE_W = CHR_REG_W + 1;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_PRG0,
        WK_PRG1,
        WK_MIRR,
        WK_CHR_LO,
        WK_CHR_HI
    } wr_kind_e;
endpackage

// File: rtl/nbr_decode.sv
// Address decoder: classifies a CPU write and picks the pattern slot.
// Assumes a 16-bit address; purely combinational, no state.
module nbr_decode
    import nbr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output wr_kind_e          kind,
    output logic [SLOT_W-1:0] slot
);
    logic              in_chr_range;
    logic [SLOT_W-1:0] slot_base;

    // Slot index from address bits 13:12 and bit 11 merged with bit 1
    always_comb begin
        slot_base = {addr[13:12], addr[11] | addr[1]};
        slot      = slot_base + SLOT_W'(2);
    end

    // Classify the write by range and top address nibble
    always_comb begin
        in_chr_range = (addr >= ADDR_W'(16'hB000)) && (addr <= ADDR_W'(16'hE003));
        kind = WK_NONE;
        if (wr) begin
            if (in_chr_range) begin
                kind = addr[0] ? WK_CHR_HI : WK_CHR_LO;
            end else begin
                case (addr[ADDR_W-1 -: 4])
                    4'h8:    kind = WK_PRG0;
                    4'h9:    kind = WK_MIRR;
                    4'hA:    kind = WK_PRG1;
                    default: kind = WK_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/nbr_regfile.sv
// Register file: two program bank bytes, a mirroring bit and eight
// pattern bank bytes loaded one nibble per write. Synchronous active-low reset.
module nbr_regfile
    import nbr_pkg::*;
#(
    parameter int PRG_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  wr_kind_e                              kind,
    input  logic [SLOT_W-1:0]                     slot,
    input  logic [7:0]                            data,
    output logic [PRG_W-1:0]                      prg0_q,
    output logic [PRG_W-1:0]                      prg1_q,
    output logic                                  mirr_q,
    output logic [CHR_SLOTS-1:0][CHR_REG_W-1:0]   chr_q
);
    // Program registers and mirroring bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prg0_q <= PRG_W'(0);
            prg1_q <= PRG_W'(1);
            mirr_q <= 1'b0;
        end else begin
            if (kind == WK_PRG0) prg0_q <= PRG_W'(data);
            if (kind == WK_PRG1) prg1_q <= PRG_W'(data);
            if (kind == WK_MIRR) mirr_q <= data[0];
        end
    end

    // One nibble-loaded pattern register per slot
    for (genvar s = 0; s < CHR_SLOTS; s++) begin : g_chr
        localparam logic [CHR_REG_W-1:0] RST_VAL =
            (s < CHR_SLOTS / 2) ? {CHR_REG_W{1'b1}} : CHR_REG_W'(s);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chr_q[s] <= RST_VAL;
            end else if (slot == SLOT_W'(s)) begin
                if (kind == WK_CHR_LO) chr_q[s][NIB_W-1:0]         <= data[NIB_W-1:0];
                if (kind == WK_CHR_HI) chr_q[s][CHR_REG_W-1:NIB_W] <= data[NIB_W-1:0];
            end
        end
    end

    // R2 R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_NONE) |=> ($stable(chr_q) && $stable(prg0_q) && $stable(prg1_q) && $stable(mirr_q)));

    // R4
    lo_nibble_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_CHR_LO) |=> (chr_q[$past(slot)][NIB_W-1:0] == $past(data[NIB_W-1:0]))
            && (chr_q[$past(slot)][CHR_REG_W-1:NIB_W] == $past(chr_q[slot][CHR_REG_W-1:NIB_W])));

    // R5
    hi_nibble_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_CHR_HI) |=> (chr_q[$past(slot)][CHR_REG_W-1:NIB_W] == $past(data[NIB_W-1:0]))
            && (chr_q[$past(slot)][NIB_W-1:0] == $past(chr_q[slot][NIB_W-1:0])));

    // R6
    prg0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_PRG0) |=> (prg0_q == PRG_W'($past(data))) && $stable(prg1_q));
endmodule

// File: rtl/nbr_xlate.sv
// Page translator: turns register contents, the bank count and the outer
// bit into page numbers. Combinational; clock only feeds the checks.
module nbr_xlate
    import nbr_pkg::*;
#(
    parameter int PRG_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [PRG_W-1:0]                      prg0_q,
    input  logic [PRG_W-1:0]                      prg1_q,
    input  logic                                  mirr_q,
    input  logic [CHR_SLOTS-1:0][CHR_REG_W-1:0]   chr_q,
    input  logic [PRG_W-1:0]                      bank_count,
    input  logic                                  outer,
    output logic [PRG_SLOTS*PRG_W-1:0]            prg_pages,
    output logic [CHR_SLOTS*CHR_PAGE_W-1:0]       chr_pages,
    output logic                                  mirror_horiz
);
    logic [PRG_W-1:0] fixed_lo;
    logic [PRG_W-1:0] fixed_hi;

    // Fixed upper pages counted back from the bank count, wrapped by it
    always_comb begin
        fixed_hi = bank_count - PRG_W'(1);
        fixed_lo = (bank_count == PRG_W'(1)) ? PRG_W'(0) : bank_count - PRG_W'(2);
        prg_pages = {fixed_hi, fixed_lo, prg1_q, prg0_q};
        mirror_horiz = mirr_q;
    end

    // Pattern pages: outer bit above each register value
    for (genvar s = 0; s < CHR_SLOTS; s++) begin : g_page
        assign chr_pages[s*CHR_PAGE_W +: CHR_PAGE_W] = {outer, chr_q[s]};

        // R9
        outer_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            chr_pages[s*CHR_PAGE_W + CHR_REG_W] == outer);
    end

    // R8
    fixed_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_count >= PRG_W'(2)) |-> (prg_pages[3*PRG_W +: PRG_W] == prg_pages[2*PRG_W +: PRG_W] + PRG_W'(1)));

    // R8
    fixed_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_count != PRG_W'(0)) |-> (prg_pages[3*PRG_W +: PRG_W] < bank_count)
            && (prg_pages[2*PRG_W +: PRG_W] < bank_count));
endmodule

// File: rtl/nibble_bank_mapper.sv
// Top: gates CPU writes with the personality enable, decodes them, holds
// the bank registers and presents page numbers. Synchronous active-low reset.
module nibble_bank_mapper
    import nbr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PRG_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic                              cpu_wr,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [7:0]                        wr_data,
    input  logic [PRG_W-1:0]                  prg_bank_count,
    input  logic                              chr_outer,
    output logic [PRG_SLOTS*PRG_W-1:0]        prg_pages,
    output logic [CHR_SLOTS*CHR_PAGE_W-1:0]   chr_pages,
    output logic                              mirror_horiz
);
    wr_kind_e                              kind;
    logic [SLOT_W-1:0]                     slot;
    logic [PRG_W-1:0]                      prg0_q;
    logic [PRG_W-1:0]                      prg1_q;
    logic                                  mirr_q;
    logic [CHR_SLOTS-1:0][CHR_REG_W-1:0]   chr_q;
    logic                                  wr_go;

    // Only accept writes while this personality is selected
    assign wr_go = cpu_wr & wr_en;

    nbr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (wr_addr),
        .wr   (wr_go),
        .kind (kind),
        .slot (slot)
    );

    nbr_regfile #(.PRG_W(PRG_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind   (kind),
        .slot   (slot),
        .data   (wr_data),
        .prg0_q (prg0_q),
        .prg1_q (prg1_q),
        .mirr_q (mirr_q),
        .chr_q  (chr_q)
    );

    nbr_xlate #(.PRG_W(PRG_W)) u_xlate (
        .clk          (clk),
        .rst_n        (rst_n),
        .prg0_q       (prg0_q),
        .prg1_q       (prg1_q),
        .mirr_q       (mirr_q),
        .chr_q        (chr_q),
        .bank_count   (prg_bank_count),
        .outer        (chr_outer),
        .prg_pages    (prg_pages),
        .chr_pages    (chr_pages),
        .mirror_horiz (mirror_horiz)
    );

    // R2
    gated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !wr_en) |=> ($stable(chr_pages) || $changed(chr_outer)) && $stable(mirror_horiz));

    // R7
    mirror_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && wr_addr[ADDR_W-1 -: 4] == 4'h9) |=> (mirror_horiz == $past(wr_data[0])));
endmodule

// File: tb/tb_nibble_bank_mapper.sv
module tb_nibble_bank_mapper;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic        cpu_wr;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    logic [7:0]  prg_bank_count;
    logic        chr_outer;
    logic [31:0] prg_pages;
    logic [71:0] chr_pages;
    logic        mirror_horiz;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    nibble_bank_mapper dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cpu_wr(cpu_wr),
        .wr_addr(wr_addr), .wr_data(wr_data), .prg_bank_count(prg_bank_count),
        .chr_outer(chr_outer), .prg_pages(prg_pages), .chr_pages(chr_pages),
        .mirror_horiz(mirror_horiz)
    );

    // Entry: {req[3:0], addr[15:0], data[7:0], sel[3:0], expected[8:0]}
    // sel 0..3 program page, 4..11 pattern slot 0..7, 12 mirroring
    localparam int NV = 19;
    localparam logic [40:0] VEC [NV] = '{
        {4'd4,  16'hB000, 8'h0A, 4'd4,  9'h0FA},  // R4 slot0 low
        {4'd5,  16'hB001, 8'h03, 4'd4,  9'h03A},  // R5 slot0 high
        {4'd3,  16'hB002, 8'h05, 4'd5,  9'h0F5},  // R3 slot1
        {4'd3,  16'hC000, 8'h01, 4'd6,  9'h0F1},  // R3 slot2
        {4'd3,  16'hC002, 8'h0C, 4'd7,  9'h0FC},  // R3 slot3
        {4'd4,  16'hD000, 8'h19, 4'd8,  9'h009},  // R4 upper data bits dropped
        {4'd5,  16'hD003, 8'h2E, 4'd9,  9'h0E5},  // R5 slot5 high
        {4'd3,  16'hE000, 8'h00, 4'd10, 9'h000},  // R3 slot6
        {4'd3,  16'hE002, 8'h0F, 4'd11, 9'h00F},  // R3 slot7
        {4'd3,  16'hB800, 8'h07, 4'd5,  9'h0F7},  // R3 alias of slot1
        {4'd6,  16'h8000, 8'h03, 4'd0,  9'h003},  // R6
        {4'd6,  16'hA000, 8'hC5, 4'd1,  9'h0C5},  // R6
        {4'd7,  16'h9000, 8'h01, 4'd12, 9'h001},  // R7
        {4'd7,  16'h9FFF, 8'hFE, 4'd12, 9'h000},  // R7
        {4'd6,  16'h8123, 8'h7F, 4'd0,  9'h07F},  // R6
        {4'd10, 16'hE004, 8'h05, 4'd10, 9'h000},  // R10
        {4'd10, 16'hF000, 8'h09, 4'd0,  9'h07F},  // R10
        {4'd10, 16'h6000, 8'h01, 4'd4,  9'h03A},  // R10
        {4'd6,  16'hAFFF, 8'h00, 4'd1,  9'h000}   // R6
    };

    function automatic logic [8:0] pick(input int sel);
        if (sel < 4)       return {1'b0, prg_pages[sel*8 +: 8]};
        else if (sel < 12) return chr_pages[(sel-4)*9 +: 9];
        else               return {8'h00, mirror_horiz};
    endfunction

    task automatic check(input string req, input int sel, input logic [8:0] exp);
        logic [8:0] got;
        got = pick(sel);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", req, sel, got, exp);
        end
    endtask

    task automatic write(input logic [15:0] a, input logic [7:0] d, input logic en);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_en = en; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; wr_en = 1'b1;
    endtask

    task automatic check_reset(input string req);
        logic [8:0] rv [13] = '{9'd0, 9'd1, 9'd35, 9'd36, 9'h0FF, 9'h0FF, 9'h0FF,
                               9'h0FF, 9'd4, 9'd5, 9'd6, 9'd7, 9'd0};
        for (int i = 0; i < 13; i++) check(req, i, rv[i]);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b1; cpu_wr = 1'b0; wr_addr = '0; wr_data = '0;
        prg_bank_count = 8'd37; chr_outer = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset("R1 R8");

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            logic [40:0] e;
            string tag;
            e = VEC[v];
            write(e[36:21], e[20:13], 1'b1);
            tag = $sformatf("R%0d", e[40:37]);
            check(tag, int'(e[12:9]), e[8:0]);
        end

        // R2: gated write leaves slot0 and program page 0 alone
        write(16'hB000, 8'h05, 1'b0);
        check("R2", 4, 9'h03A);
        write(16'h8000, 8'h44, 1'b0);
        check("R2", 0, 9'h07F);

        // R11: no change before the capturing edge
        @(negedge clk);
        wr_addr = 16'h8000; wr_data = 8'h11; cpu_wr = 1'b1; wr_en = 1'b1;
        #5;
        check("R11", 0, 9'h07F);
        @(negedge clk);
        cpu_wr = 1'b0;
        check("R11", 0, 9'h011);

        // R8: bank count wrap cases
        prg_bank_count = 8'd1;   #1; check("R8", 2, 9'd0);   check("R8", 3, 9'd0);
        prg_bank_count = 8'd2;   #1; check("R8", 2, 9'd0);   check("R8", 3, 9'd1);
        prg_bank_count = 8'd0;   #1; check("R8", 2, 9'd254); check("R8", 3, 9'd255);
        prg_bank_count = 8'd255; #1; check("R8", 2, 9'd253); check("R8", 3, 9'd254);
        prg_bank_count = 8'd37;

        // R9: outer bit over loaded values
        chr_outer = 1'b1; #1;
        check("R9", 4, 9'h13A);
        check("R9", 8, 9'h109);
        chr_outer = 1'b0; #1;
        check("R9", 4, 9'h03A);

        // R1: reset mid-run restores every register
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_reset("R1");

        finish_run();
    end
endmodule